// File: doc/BRIEF.md
# ADC Conversion Sequencer with Channel Selection Latch

This block is the digital control sequencer for a successive-approximation analog-to-digital converter. Software writes a channel/reference selection word into a buffer register. The block passes that word on to the analog multiplexer only at points where doing so cannot disturb a sample. While the converter is idle, the multiplexer selection follows the buffer. Once a conversion is under way, the selection is held. It is released again for the final eight converter clock periods, so that a new choice is ready for the next conversion.

A conversion starts on a software start request or, in auto-trigger mode, on an external trigger pulse. The block times the sample-and-hold strobe and the end of conversion for three conversion kinds:

- the first conversion after the converter is enabled;
- a normal software-started conversion;
- an auto-triggered conversion.

The block runs from a clock at twice the converter clock rate, so every timing point, including the half-cycle ones, falls on a clock edge. All timings below are stated in these half-period clock cycles.

At completion, the block latches the result from a behavioural result input, which stands in for the comparator and SAR logic. It sets a completion flag and presents the result as a high byte and a low byte.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A selection write (`sel_wr` high) loads `sel_din` into the buffer at that clock edge. While no conversion is busy, `mux_sel` takes the buffer value at the following edge.
- R2: From the edge that starts a conversion, `mux_sel` holds its value. It copies the buffer again only once the conversion has reached its last 16 half-cycles (8 converter cycles). So a selection written after the start applies to the next conversion.
- R3: A start request sampled at clock edge k raises `busy` at edge k+1 (the second edge counting the sampling edge). It does so only when `en` is high.
- R4: The first conversion after `en` rises pulses `sh_strobe` 27 half-cycles after `busy` rises. It keeps `busy` high for 50 half-cycles.
- R5: A normal software-started conversion pulses `sh_strobe` at half-cycle 7 and lasts 31 half-cycles.
- R6: With `en` and `auto_en` high, a `trig` pulse starts an auto-triggered conversion. It pulses `sh_strobe` at half-cycle 4 and lasts 32 half-cycles.
- R7: At the edge where `busy` falls, `done_flag` sets and the result is latched. `res_hi` holds `res_in[RES_W-1:8]` zero-extended, and `res_lo` holds `res_in[7:0]`.
- R8: `flag_clr` high clears `done_flag` at the next edge. A completion at the same edge wins over the clear.
- R9: These requests are ignored and start nothing:
  - `start_wr` or `trig` while a conversion is busy or about to start;
  - any request while `en` is low;
  - `trig` while `auto_en` is low.
- R10: First-conversion timing is used once after each rise of `en`, whatever the start source. Later conversions use normal or auto-triggered timing.
- R11: `res_hi` and `res_lo` are zero after reset and keep their value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Converter enable |
| auto_en | input | 1 | Auto-trigger mode enable |
| start_wr | input | 1 | Software start request pulse |
| trig | input | 1 | Auto-trigger event pulse |
| sel_wr | input | 1 | Selection buffer write strobe |
| sel_din | input | SEL_W | Channel/reference selection write data |
| flag_clr | input | 1 | Write-one-to-clear for the completion flag |
| res_in | input | RES_W | Behavioural conversion result |
| mux_sel | output | SEL_W | Selection driving the analog multiplexer |
| busy | output | 1 | Conversion in progress |
| sh_strobe | output | 1 | Sample-and-hold instant, one cycle |
| done_flag | output | 1 | Completion flag |
| res_hi | output | 8 | Result high byte |
| res_lo | output | 8 | Result low byte |

## Verification
The bench builds the block with `SEL_W = 4` and `RES_W = 12`, and keeps the timing parameters at their defaults. A 12-bit result puts four significant bits into the high byte, so a wrong split or a wrong zero-extension of the upper part shows up as a wrong value.

With the default timings, all three conversion kinds can be run back to back within a few hundred cycles. The 16-half-cycle release window is reachable inside the shortest conversion, which makes the hold and the release of the selection observable in one run.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the ADC conversion sequencer.
// Assumes all timing values are counted in half converter clock periods.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        CONV_FIRST  = 2'd0,
        CONV_NORMAL = 2'd1,
        CONV_AUTO   = 2'd2
    } conv_kind_e;

    // Largest of three integers, used to size the half-cycle counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Smallest of three integers, used for the shortest conversion.
    function automatic int min3(input int a, input int b, input int c);
        int m;
        m = (a < b) ? a : b;
        return (m < c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_start_ctl.sv
`timescale 1ns/1ps
// Module: adc_start_ctl
// Accepts software start and auto-trigger requests. It registers an accepted
// request for one cycle, so that the conversion begins on the second edge
// after the request is sampled. It also picks the conversion kind.
// Assumes start_wr and trig are single-cycle pulses synchronous to clk.
module adc_start_ctl
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       auto_en,
    input  logic       start_wr,
    input  logic       trig,
    input  logic       busy,
    output logic       launch,
    output conv_kind_e launch_kind
);

    logic en_q;
    logic first_pend;
    logic pend;
    logic req;
    logic en_rise;

    assign en_rise = en && !en_q;

    // Accept a request only when enabled, idle and nothing is already queued.
    assign req = en && !busy && !pend && (start_wr || (auto_en && trig));

    // Track the enable edge that arms the first-conversion timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            first_pend <= 1'b0;
        end else begin
            en_q <= en;
            if (req)
                first_pend <= 1'b0;
            else if (en_rise)
                first_pend <= 1'b1;
        end
    end

    // One-cycle request stage and the kind chosen at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend        <= 1'b0;
            launch_kind <= CONV_NORMAL;
        end else begin
            pend <= req;
            if (req) begin
                if (first_pend || en_rise)
                    launch_kind <= CONV_FIRST;
                else if (start_wr)
                    launch_kind <= CONV_NORMAL;
                else
                    launch_kind <= CONV_AUTO;
            end
        end
    end

    assign launch = pend;

endmodule

// File: rtl/adc_conv_timer.sv
`timescale 1ns/1ps
// Module: adc_conv_timer
// Counts half converter cycles during a conversion. It produces the
// sample-and-hold strobe, the final-cycle indication and the window in which
// the multiplexer selection may follow its buffer again.
// Assumes launch never arrives while busy (the start control blocks it).
module adc_conv_timer
    import adc_seq_pkg::*;
#(
    parameter int SAMP_FIRST = 27,
    parameter int END_FIRST  = 50,
    parameter int SAMP_NORM  = 7,
    parameter int END_NORM   = 31,
    parameter int SAMP_AUTO  = 4,
    parameter int END_AUTO   = 32,
    parameter int RESUME_H   = 16,
    parameter int CNT_W      = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  conv_kind_e launch_kind,
    output logic       busy,
    output logic       sh_strobe,
    output logic       finish,
    output logic       resume
);

    logic [CNT_W-1:0] cnt;
    conv_kind_e       kind_r;
    logic [CNT_W-1:0] samp_pt;
    logic [CNT_W-1:0] end_pt;
    logic [CNT_W-1:0] last_pt;
    logic [CNT_W-1:0] open_pt;

    // Look up the timing points of the conversion kind in progress.
    always_comb begin
        case (kind_r)
            CONV_FIRST: begin
                samp_pt = CNT_W'(SAMP_FIRST);
                end_pt  = CNT_W'(END_FIRST);
            end
            CONV_AUTO: begin
                samp_pt = CNT_W'(SAMP_AUTO);
                end_pt  = CNT_W'(END_AUTO);
            end
            default: begin
                samp_pt = CNT_W'(SAMP_NORM);
                end_pt  = CNT_W'(END_NORM);
            end
        endcase
        last_pt = end_pt - CNT_W'(1);
        open_pt = end_pt - CNT_W'(RESUME_H);
    end

    // Run the half-cycle counter from launch to the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            kind_r <= CONV_NORMAL;
        end else if (!busy) begin
            if (launch) begin
                busy   <= 1'b1;
                cnt    <= '0;
                kind_r <= launch_kind;
            end
        end else if (cnt == last_pt) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign sh_strobe = busy && (cnt == samp_pt);
    assign finish    = busy && (cnt == last_pt);
    assign resume    = busy && (cnt >= open_pt);

endmodule

// File: rtl/adc_sel_latch.sv
`timescale 1ns/1ps
// Module: adc_sel_latch
// Holds the software-visible selection buffer and the copy that drives the
// analog multiplexer. The copy follows the buffer except while a conversion
// is in its protected span.
// Assumes the resume input is high only during the final window of a conversion.
module adc_sel_latch #(
    parameter int SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_din,
    input  logic             busy,
    input  logic             resume,
    output logic [SEL_W-1:0] mux_sel
);

    logic [SEL_W-1:0] sel_buf;

    // Capture software writes into the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_buf <= '0;
        else if (sel_wr)
            sel_buf <= sel_din;
    end

    // Copy the buffer to the multiplexer when it is safe to do so.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mux_sel <= '0;
        else if (!busy || resume)
            mux_sel <= sel_buf;
    end

endmodule

// File: rtl/adc_result_reg.sv
`timescale 1ns/1ps
// Module: adc_result_reg
// Latches the conversion result and raises the completion flag at the final
// cycle. It presents the result as a zero-extended high byte and a low byte.
// Assumes 9 <= RES_W <= 16.
module adc_result_reg #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             finish,
    input  logic             flag_clr,
    input  logic [RES_W-1:0] res_in,
    output logic             done_flag,
    output logic [7:0]       res_hi,
    output logic [7:0]       res_lo
);

    logic [RES_W-1:0] res_r;
    logic [15:0]      res_wide;

    // Set on completion (wins over a clear), cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_flag <= 1'b0;
        else if (finish)
            done_flag <= 1'b1;
        else if (flag_clr)
            done_flag <= 1'b0;
    end

    // Capture the result at completion and hold it until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_r <= '0;
        else if (finish)
            res_r <= res_in;
    end

    assign res_wide = 16'(res_r);
    assign res_hi   = res_wide[15:8];
    assign res_lo   = res_wide[7:0];

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
// Module: adc_seq_ctrl (top)
// Conversion sequencer for a successive-approximation ADC. It ties together
// start control, the half-cycle timer, the selection latch and the result
// register. Assumes clk runs at twice the converter clock rate, and that
// res_in is valid in the final cycle of a conversion.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SEL_W      = 5,
    parameter int RES_W      = 10,
    parameter int SAMP_FIRST = 27,
    parameter int END_FIRST  = 50,
    parameter int SAMP_NORM  = 7,
    parameter int END_NORM   = 31,
    parameter int SAMP_AUTO  = 4,
    parameter int END_AUTO   = 32,
    parameter int RESUME_H   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             auto_en,
    input  logic             start_wr,
    input  logic             trig,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_din,
    input  logic             flag_clr,
    input  logic [RES_W-1:0] res_in,
    output logic [SEL_W-1:0] mux_sel,
    output logic             busy,
    output logic             sh_strobe,
    output logic             done_flag,
    output logic [7:0]       res_hi,
    output logic [7:0]       res_lo
);

    localparam int MAX_END = max3(END_FIRST, END_NORM, END_AUTO);
    localparam int MIN_END = min3(END_FIRST, END_NORM, END_AUTO);
    localparam int CNT_W   = $clog2(MAX_END + 1);

    logic       launch;
    conv_kind_e launch_kind;
    logic       finish;
    logic       resume;

    adc_start_ctl u_start (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .auto_en     (auto_en),
        .start_wr    (start_wr),
        .trig        (trig),
        .busy        (busy),
        .launch      (launch),
        .launch_kind (launch_kind)
    );

    adc_conv_timer #(
        .SAMP_FIRST (SAMP_FIRST),
        .END_FIRST  (END_FIRST),
        .SAMP_NORM  (SAMP_NORM),
        .END_NORM   (END_NORM),
        .SAMP_AUTO  (SAMP_AUTO),
        .END_AUTO   (END_AUTO),
        .RESUME_H   (RESUME_H),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_kind (launch_kind),
        .busy        (busy),
        .sh_strobe   (sh_strobe),
        .finish      (finish),
        .resume      (resume)
    );

    adc_sel_latch #(
        .SEL_W (SEL_W)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_wr  (sel_wr),
        .sel_din (sel_din),
        .busy    (busy),
        .resume  (resume),
        .mux_sel (mux_sel)
    );

    adc_result_reg #(
        .RES_W (RES_W)
    ) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .finish    (finish),
        .flag_clr  (flag_clr),
        .res_in    (res_in),
        .done_flag (done_flag),
        .res_hi    (res_hi),
        .res_lo    (res_lo)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
// Module: adc_seq_ctrl_chk
// Port-level properties of the conversion sequencer, bound to the top module.
// Keeps its own count of cycles since busy rose, to locate the protected span.
module adc_seq_ctrl_chk #(
    parameter int SEL_W     = 5,
    parameter int HOLD_LAST = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             sh_strobe,
    input logic             done_flag,
    input logic             flag_clr,
    input logic [SEL_W-1:0] mux_sel,
    input logic [7:0]       res_hi,
    input logic [7:0]       res_lo
);

    logic [7:0] age;

    // Count cycles spent busy since the conversion started.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= '0;
        else if (busy)
            age <= age + 8'd1;
        else
            age <= '0;
    end

    assert_sel_frozen_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && age >= 8'd1 && age <= 8'(HOLD_LAST)) |-> $stable(mux_sel));

    assert_busy_min_len_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    assert_strobe_in_conv_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        sh_strobe |-> busy);

    assert_flag_on_end_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);

    assert_flag_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !busy) |=> !done_flag);

    assert_result_hold_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable({res_hi, res_lo}));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .SEL_W     (SEL_W),
    .HOLD_LAST (MIN_END - RESUME_H)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .sh_strobe (sh_strobe),
    .done_flag (done_flag),
    .flag_clr  (flag_clr),
    .mux_sel   (mux_sel),
    .res_hi    (res_hi),
    .res_lo    (res_lo)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
// Bench for adc_seq_ctrl. A driver task queues the expected timing and
// result of each conversion; a monitor measures them and compares.
module adc_seq_ctrl_test;

    localparam int SEL_W = 4;
    localparam int RES_W = 12;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             en, auto_en, start_wr, trig, sel_wr, flag_clr;
    logic [SEL_W-1:0] sel_din;
    logic [RES_W-1:0] res_in;
    logic [SEL_W-1:0] mux_sel;
    logic             busy, sh_strobe, done_flag;
    logic [7:0]       res_hi, res_lo;

    int total_chk = 0;
    int bad_chk   = 0;
    bit finished  = 1'b0;

    typedef struct {
        int    samp;
        int    len;
        int    hi;
        int    lo;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    adc_seq_ctrl #(.SEL_W(SEL_W), .RES_W(RES_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .auto_en   (auto_en),
        .start_wr  (start_wr),
        .trig      (trig),
        .sel_wr    (sel_wr),
        .sel_din   (sel_din),
        .flag_clr  (flag_clr),
        .res_in    (res_in),
        .mux_sel   (mux_sel),
        .busy      (busy),
        .sh_strobe (sh_strobe),
        .done_flag (done_flag),
        .res_hi    (res_hi),
        .res_lo    (res_lo)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total_chk++;
        if (!ok) begin
            bad_chk++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: measure strobe offset and busy length of each conversion.
    initial begin
        int  age;
        int  sh_age;
        bit  pbusy;
        bit  pflag;
        age = 0; sh_age = -1; pbusy = 1'b0; pflag = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (busy && !pbusy) begin
                    age = 0;
                    sh_age = -1;
                end else if (busy) begin
                    age++;
                end
                if (busy && sh_strobe) sh_age = age;
                if (done_flag && !pflag) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9", "unexpected conversion", 1, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(sh_age == e.samp, e.req, "strobe offset", sh_age, e.samp);
                        check(age + 1 == e.len, e.req, "busy length", age + 1, e.len);
                        check(int'(res_hi) == e.hi, "R7", "res_hi", res_hi, e.hi);
                        check(int'(res_lo) == e.lo, "R7", "res_lo", res_lo, e.lo);
                    end
                end
                pbusy = busy;
                pflag = done_flag;
            end
        end
    end

    // Driver: queue the expectation, issue the request, wait and clear the flag.
    task automatic run_conv(input bit use_trig, input int samp, input int len,
                            input int val, input string req);
        exp_t e;
        e.samp = samp; e.len = len; e.hi = val >> 8; e.lo = val & 255; e.req = req;
        exp_q.push_back(e);
        res_in = RES_W'(val);
        if (use_trig) trig = 1'b1; else start_wr = 1'b1;
        tick(1);
        trig = 1'b0; start_wr = 1'b0;
        while (!done_flag) tick(1);
        check(done_flag == 1'b1, "R8", "flag set before clear", done_flag, 1);
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        check(done_flag == 1'b0, "R8", "flag after clear", done_flag, 0);
        tick(2);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            total_chk++;
            bad_chk++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; auto_en = 1'b0; start_wr = 1'b0; trig = 1'b0;
        sel_wr = 1'b0; sel_din = '0; flag_clr = 1'b0; res_in = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check(busy == 1'b0, "R3", "reset busy", busy, 0);
        check(done_flag == 1'b0, "R7", "reset flag", done_flag, 0);
        check(res_hi == 8'd0 && res_lo == 8'd0, "R11", "reset result",
              {res_hi, res_lo}, 0);
        check(mux_sel == '0, "R1", "reset mux_sel", mux_sel, 0);

        // R1: the buffer write lands at one edge, the mux copy at the next.
        sel_wr = 1'b1; sel_din = 4'h5;
        tick(1);
        sel_wr = 1'b0;
        check(mux_sel == 4'h0, "R1", "mux one edge after write", mux_sel, 0);
        tick(1);
        check(mux_sel == 4'h5, "R1", "mux two edges after write", mux_sel, 5);

        // R9: no start while disabled.
        start_wr = 1'b1;
        tick(1);
        start_wr = 1'b0;
        tick(4);
        check(busy == 1'b0, "R9", "start with en low", busy, 0);

        // R9: trig ignored without auto mode.
        en = 1'b1;
        tick(1);
        trig = 1'b1;
        tick(1);
        trig = 1'b0;
        tick(4);
        check(busy == 1'b0, "R9", "trig with auto_en low", busy, 0);

        // R4/R10: first conversion after enable.
        run_conv(1'b0, 27, 50, 12'hABC, "R4");
        // R5: normal conversion.
        run_conv(1'b0, 7, 31, 12'h3F1, "R5");
        // R6: auto-triggered conversion.
        auto_en = 1'b1;
        run_conv(1'b1, 4, 32, 12'hF0E, "R6");

        // R3, R2, R9: latency, selection hold/release, requests while busy.
        sel_wr = 1'b1; sel_din = 4'h3;
        tick(1);
        sel_wr = 1'b0;
        tick(2);
        begin
            exp_t e;
            e.samp = 7; e.len = 31; e.hi = 8'h07; e.lo = 8'h65; e.req = "R5";
            exp_q.push_back(e);
        end
        res_in = 12'h765;
        start_wr = 1'b1;
        tick(1);
        start_wr = 1'b0;
        check(busy == 1'b0, "R3", "busy one edge after request", busy, 0);
        tick(1);
        check(busy == 1'b1, "R3", "busy two edges after request", busy, 1);
        sel_wr = 1'b1; sel_din = 4'h9;
        tick(1);
        sel_wr = 1'b0;
        start_wr = 1'b1; trig = 1'b1;
        tick(1);
        start_wr = 1'b0; trig = 1'b0;
        tick(8);
        check(mux_sel == 4'h3, "R2", "mux held mid conversion", mux_sel, 3);
        tick(10);
        check(mux_sel == 4'h9, "R2", "mux released in final window", mux_sel, 9);
        while (!done_flag) tick(1);
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        tick(4);
        check(busy == 1'b0, "R9", "no extra conversion after busy requests", busy, 0);

        // R11: result holds while idle.
        tick(10);
        check(res_hi == 8'h07 && res_lo == 8'h65, "R11", "result held",
              {res_hi, res_lo}, 16'h0765);

        // R10: re-enabling arms first timing even for a trigger start.
        en = 1'b0;
        tick(2);
        en = 1'b1;
        tick(1);
        run_conv(1'b1, 27, 50, 12'h9AB, "R10");

        tick(5);
        check(exp_q.size() == 0, "R9", "all expected conversions seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

endmodule